// File: doc/BRIEF.md
# Clocked Serial Receiver with Byte Queue

This block is the receive half of a clocked-synchronous serial port. An external serial clock and data line are brought into the system clock domain through a short synchronizer. On every rising edge of the serial clock one data bit is taken, most significant bit first. Each completed byte is placed into a first-in first-out queue. A host reads the queue through a small register file, and a DMA engine can read it through a dedicated acknowledge strobe.

A ready flag rises once the queue holds at least a programmable number of bytes. Its rising edge produces a one-cycle interrupt request pulse. Software may clear the flag only if it has first read the flag as 1. A DMA read clears the flag by itself. If a byte completes while the queue is full, the byte is dropped and an overrun flag is raised. While that flag is set, the receiver ignores the line entirely, until software writes the flag back to 0.

Register map (2-bit address, `DATA_W`-bit data). Address 0 is control: bit 0 enables reception, and bits 2:1 select the trigger level. Address 1 is status: bit 0 is the ready flag and bit 1 is the overrun flag. Address 2 is the data port, and a read pulse there pops one byte. Address 3 returns the number of bytes held.

Top module: `csync_rx`

## Requirements
- R1: Serial bits are taken on rising serial-clock edges, most significant bit first. Eight bits form one byte. Bytes are read back at address 2, and on `dma_data_o`, in arrival order. Address 2 returns 0 when the queue is empty.
- R2: Address 3 returns the number of bytes held. A byte appears in the count on the third system-clock edge after the serial clock that carried its last bit goes high.
- R3: The ready flag (status bit 0) becomes 1 one clock after the byte count is at or above the trigger level. Trigger codes 0, 1, 2 and 3 in control bits 2:1 select 1, 4, 8 and DEPTH-2 (14) bytes.
- R4: `irq_o` is high for exactly one clock, in the first clock in which the ready flag reads 1 after having been 0.
- R5: Writing status bit 0 as 0 clears the ready flag only if the flag was read as 1 at address 1 after it last became 1. Otherwise the write has no effect. Writing bit 0 as 1 never changes the flag.
- R6: When a permitted software clear leaves the count at or above the trigger level, the flag reads 0 for one clock and then 1 again, and a new interrupt pulse follows.
- R7: A `dma_ack_i` pulse pops one byte and clears the ready flag in the same clock, without any software write.
- R8: A byte that completes while the queue already holds DEPTH (16) bytes, with no read in the same clock, is discarded. The overrun flag (status bit 1) is then set.
- R9: While the overrun flag is 1, no bit is taken and the byte count never grows. Writing status bit 1 as 0 clears the flag, and reception then restarts at a byte boundary.
- R10: Clearing the enable bit (control bit 0) lets a byte already in progress finish. No new byte starts while the bit is 0.
- R11: After reset, control, status and count all read 0, and `irq_o` is 0.
- R12: The byte count never exceeds DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | External serial clock |
| sdat_i | input | 1 | Serial data line |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe; pops the queue at address 2 |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational on address) |
| dma_ack_i | input | 1 | DMA read acknowledge; pops one byte, clears ready |
| dma_data_o | output | DATA_W | Byte at the head of the queue |
| irq_o | output | 1 | Receive-data interrupt pulse |

## Verification
The bench targets the points where the ready flag can go wrong. One case is a clear written without a prior read of 1: a design that skips the read-before-clear guard would drop the flag. Another is a permitted clear while the count is still above the trigger: a design lacking the re-set would leave the flag low with data waiting. A third is a DMA acknowledge: a design that leaves the flag alone would hold the request up after the queue was read. On overrun, the bench checks two things. The seventeenth byte must not replace stored data. The bits sent while the flag is set must not be stitched onto the next byte once the flag is cleared; a design that does this would misalign every later byte. It also disables reception in the middle of a byte. A design that stops at once would lose that byte, and one that ignores the disable would accept the next byte.

// File: rtl/csync_rx_pkg.sv
package csync_rx_pkg;

   typedef enum logic [1:0] {
      REG_CTRL = 2'd0,
      REG_STAT = 2'd1,
      REG_DATA = 2'd2,
      REG_LVL  = 2'd3
   } reg_sel_e;

   // trigger code to byte threshold; the top code tracks the queue depth
   function automatic int unsigned trig_level(input logic [1:0] code, input int unsigned depth);
      case (code)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/csync_rx_sync.sv
module csync_rx_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sclk_i,
   input  logic sdat_i,
   output logic rise_o,
   output logic bit_o
);
   logic [STAGES-1:0][1:0] st_q;
   logic                   clk_prev_q;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= {sdat_i, sclk_i};
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= '0;
            else        st_q <= {st_q[STAGES-2:0], {sdat_i, sclk_i}};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clk_prev_q <= 1'b0;
      else        clk_prev_q <= st_q[STAGES-1][0];
   end

   assign rise_o = st_q[STAGES-1][0] & ~clk_prev_q;
   assign bit_o  = st_q[STAGES-1][1];

   // R1: an edge is reported for one cycle only
   p_rise_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/csync_rx_deser.sv
module csync_rx_deser #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rise_i,
   input  logic         bit_i,
   input  logic         en_i,
   input  logic         hold_i,
   output logic         byte_v_o,
   output logic [W-1:0] byte_o
);
   localparam int unsigned CW = (W > 2) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic [CW-1:0] bcnt_q;
   logic [W-1:0]  sh_q;
   logic          take;

   assign take     = rise_i && !hold_i && (en_i || (bcnt_q != '0));
   assign byte_o   = {sh_q[W-2:0], bit_i};
   assign byte_v_o = take && (bcnt_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt_q <= '0;
         sh_q   <= '0;
      end else if (hold_i) begin
         bcnt_q <= '0;
      end else if (take) begin
         sh_q   <= byte_o;
         bcnt_q <= (bcnt_q == LAST) ? '0 : bcnt_q + 1'b1;
      end
   end

   // R9: a held receiver always restarts on a byte boundary
   p_hold_resync_r9: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> bcnt_q == '0);
   // R1: bit index stays inside the byte
   p_bcnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
      bcnt_q <= LAST);

endmodule

// File: rtl/csync_rx_fifo.sv
module csync_rx_fifo #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push_i,
   input  logic [W-1:0]               wdata_i,
   input  logic                       pop_i,
   output logic [W-1:0]               head_o,
   output logic [$clog2(DEPTH):0]     cnt_o,
   output logic                       ovf_o
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   logic [W-1:0]  mem_q [DEPTH];
   logic [AW-1:0] wp_q, rp_q;
   logic [CW-1:0] cnt_q;
   logic          full, empty, pop_ok, push_ok;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign pop_ok  = pop_i && !empty;
   assign push_ok = push_i && (!full || pop_ok);
   assign ovf_o   = push_i && full && !pop_ok;
   assign head_o  = empty ? '0 : mem_q[rp_q];
   assign cnt_o   = cnt_q;

   always_ff @(posedge clk) begin
      if (push_ok) mem_q[wp_q] <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push_ok) wp_q <= wp_q + 1'b1;
         if (pop_ok)  rp_q <= rp_q + 1'b1;
         if (push_ok && !pop_ok)      cnt_q <= cnt_q + 1'b1;
         else if (pop_ok && !push_ok) cnt_q <= cnt_q - 1'b1;
      end
   end

   // R12: occupancy bound
   p_no_overflow_r12: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(DEPTH));
   // R8: a rejected byte leaves the occupancy untouched
   p_drop_keeps_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> cnt_q == $past(cnt_q));

endmodule

// File: rtl/csync_rx.sv
module csync_rx
   import csync_rx_pkg::*;
#(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_i,
   input  logic              sdat_i,
   input  logic [1:0]        reg_addr_i,
   input  logic              reg_wr_i,
   input  logic              reg_rd_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o,
   input  logic              dma_ack_i,
   output logic [DATA_W-1:0] dma_data_o,
   output logic              irq_o
);
   localparam int unsigned CNT_W = $clog2(DEPTH) + 1;

   generate
      if (DEPTH < 16 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("csync_rx: DEPTH must be a power of two of at least 16");
      end
      if (DATA_W < 3 || DATA_W < CNT_W) begin : g_bad_width
         $error("csync_rx: DATA_W too narrow for the register fields");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("csync_rx: SYNC_STAGES must be at least 1");
      end
   endgenerate

   logic              rx_en_q, rdf_q, armed_q, ovr_q, irq_q;
   logic [1:0]        tsel_q;
   logic              rise, sbit, byte_v, ovf;
   logic [DATA_W-1:0] byte_w, head;
   logic [CNT_W-1:0]  cnt, trig;
   logic              wr_ctrl, wr_stat, rd_stat, pop, rdf_clr, rdf_d;
   logic              unused_ok;

   assign unused_ok = ^reg_wdata_i;

   csync_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sdat_i(sdat_i),
      .rise_o(rise), .bit_o(sbit));

   csync_rx_deser #(.W(DATA_W)) u_deser (
      .clk(clk), .rst_n(rst_n), .rise_i(rise), .bit_i(sbit),
      .en_i(rx_en_q), .hold_i(ovr_q), .byte_v_o(byte_v), .byte_o(byte_w));

   csync_rx_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push_i(byte_v), .wdata_i(byte_w),
      .pop_i(pop), .head_o(head), .cnt_o(cnt), .ovf_o(ovf));

   assign wr_ctrl = reg_wr_i && (reg_addr_i == REG_CTRL);
   assign wr_stat = reg_wr_i && (reg_addr_i == REG_STAT);
   assign rd_stat = reg_rd_i && (reg_addr_i == REG_STAT);
   assign pop     = (reg_rd_i && (reg_addr_i == REG_DATA)) || dma_ack_i;
   assign trig    = CNT_W'(trig_level(tsel_q, DEPTH));
   assign rdf_clr = dma_ack_i || (wr_stat && !reg_wdata_i[0] && armed_q);
   assign rdf_d   = rdf_clr ? 1'b0 : (rdf_q | (cnt >= trig));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_en_q <= 1'b0;
         tsel_q  <= 2'd0;
         rdf_q   <= 1'b0;
         armed_q <= 1'b0;
         ovr_q   <= 1'b0;
         irq_q   <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            rx_en_q <= reg_wdata_i[0];
            tsel_q  <= reg_wdata_i[2:1];
         end
         rdf_q <= rdf_d;
         irq_q <= rdf_d & ~rdf_q;
         if (rdf_clr)               armed_q <= 1'b0;
         else if (rd_stat && rdf_q) armed_q <= 1'b1;
         if (ovf)                              ovr_q <= 1'b1;
         else if (wr_stat && !reg_wdata_i[1])  ovr_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_sel_e'(reg_addr_i))
         REG_CTRL: begin
            reg_rdata_o[0]   = rx_en_q;
            reg_rdata_o[2:1] = tsel_q;
         end
         REG_STAT: begin
            reg_rdata_o[0] = rdf_q;
            reg_rdata_o[1] = ovr_q;
         end
         REG_DATA: reg_rdata_o = head;
         default:  reg_rdata_o[CNT_W-1:0] = cnt;
      endcase
   end

   assign dma_data_o = head;
   assign irq_o      = irq_q;

   // R4: the request pulse marks the first cycle of a raised flag
   p_irq_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (rdf_q && !$past(rdf_q)));
   // R3: the flag only rises after the threshold was met
   p_rdf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rdf_q) |-> $past(cnt >= trig));
   // R5 / R7: the flag only falls on a status write of 0 or a DMA read
   p_rdf_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(rdf_q) |-> $past(dma_ack_i || (wr_stat && !reg_wdata_i[0])));
   // R9: no byte enters while overrun is pending
   p_ovr_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ovr_q |=> cnt <= $past(cnt));

endmodule

// File: tb/csync_rx_bench.sv
`timescale 1ns/1ps
module csync_rx_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sclk = 1'b0, sdat = 1'b0;
   logic [1:0] addr = 2'd0;
   logic       wr = 1'b0, rd = 1'b0, dma = 1'b0;
   logic [7:0] wd = 8'd0;
   logic [7:0] rdata, ddata;
   logic       irq;

   int vectors = 0, miscompares = 0, irq_seen = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   csync_rx u_csync_rx (
      .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd), .reg_wdata_i(wd),
      .reg_rdata_o(rdata), .dma_ack_i(dma), .dma_data_o(ddata), .irq_o(irq));

   // ---------------- behavioural reference ----------------
   logic [7:0] q[$];
   bit m_s1, m_s2, m_s3, m_d1, m_d2;
   int m_bits;
   logic [7:0] m_sh;
   bit m_rdf, m_arm, m_ovr, m_irq, m_en;
   logic [1:0] m_tsel;

   function automatic int lvl(input logic [1:0] c);
      return (c == 2'd0) ? 1 : (c == 2'd1) ? 4 : (c == 2'd2) ? 8 : 14;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q.delete();
         {m_s1, m_s2, m_s3, m_d1, m_d2} = '0;
         m_bits = 0; m_sh = '0;
         {m_rdf, m_arm, m_ovr, m_irq, m_en} = '0;
         m_tsel = 2'd0;
      end else begin
         bit rise, fin, drop, popok, clr, nrdf;
         int old_n;
         logic [7:0] nb;
         rise  = m_s2 && !m_s3;
         old_n = q.size();
         popok = ((rd && addr == 2'd2) || dma) && old_n > 0;
         fin = 0; drop = 0; nb = '0;
         if (m_ovr) m_bits = 0;
         else if (rise && (m_en || m_bits != 0)) begin
            nb = {m_sh[6:0], m_d2};
            m_sh = nb;
            if (m_bits == 7) begin fin = 1; m_bits = 0; end
            else m_bits++;
         end
         if (popok) void'(q.pop_front());
         if (fin) begin
            if (old_n < 16 || popok) q.push_back(nb);
            else drop = 1;
         end
         clr  = dma || (wr && addr == 2'd1 && !wd[0] && m_arm);
         nrdf = clr ? 1'b0 : (m_rdf || old_n >= lvl(m_tsel));
         if (clr) m_arm = 0;
         else if (rd && addr == 2'd1 && m_rdf) m_arm = 1;
         m_irq = nrdf && !m_rdf;
         m_rdf = nrdf;
         if (drop) m_ovr = 1;
         else if (wr && addr == 2'd1 && !wd[1]) m_ovr = 0;
         if (wr && addr == 2'd0) begin m_en = wd[0]; m_tsel = wd[2:1]; end
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = sclk;
         m_d2 = m_d1; m_d1 = sdat;
      end
   end

   function automatic logic [7:0] exp_rdata(input logic [1:0] a);
      case (a)
         2'd0:    return {5'd0, m_tsel, m_en};
         2'd1:    return {6'd0, m_ovr, m_rdf};
         2'd2:    return (q.size() > 0) ? q[0] : 8'd0;
         default: return 8'(q.size());
      endcase
   endfunction

   always @(posedge clk) begin
      #1;
      if (rst_n && !done) begin
         logic [7:0] e;
         e = exp_rdata(addr);
         vectors++;
         if (rdata !== e) begin
            miscompares++;
            $display("FAIL R1/R2/R3 reg %0d: rdata act %h exp %h", addr, rdata, e);
         end
         if (ddata !== ((q.size() > 0) ? q[0] : 8'd0)) begin
            miscompares++;
            $display("FAIL R7 dma_data act %h exp %h", ddata, (q.size() > 0) ? q[0] : 8'd0);
         end
         if (irq !== m_irq) begin
            miscompares++;
            $display("FAIL R4 irq act %b exp %b", irq, m_irq);
         end
         if (irq) irq_seen++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic chk(input string tag, input int act, input int exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s act %0h exp %0h", tag, act, exp);
      end
   endtask

   task automatic wreg(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk); addr = a; wd = d; wr = 1'b1;
      @(negedge clk); wr = 1'b0;
   endtask

   task automatic rreg(input logic [1:0] a);
      @(negedge clk); addr = a; rd = 1'b1;
      @(negedge clk); rd = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output int v);
      @(negedge clk); addr = a; #1; v = int'(rdata);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = n - 1; i >= 0; i--) begin
         @(negedge clk); sdat = b[i]; sclk = 1'b0;
         repeat (2) @(negedge clk);
         sclk = 1'b1;
         repeat (3) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse_dma();
      @(negedge clk); dma = 1'b1;
      @(negedge clk); dma = 1'b0;
   endtask

   task automatic finish_run();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      vectors++; miscompares++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      int v, base;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      peek(2'd0, v); chk("R11 ctrl after reset", v, 0);
      peek(2'd1, v); chk("R11 status after reset", v, 0);
      peek(2'd3, v); chk("R11 count after reset", v, 0);
      chk("R11 irq after reset", int'(irq), 0);

      // R1: capture order, trigger code 0 (one byte)
      wreg(2'd0, 8'h01);
      send_bits(8'hA5, 8);
      send_bits(8'h3C, 8);
      peek(2'd3, v); chk("R2 count two bytes", v, 2);
      peek(2'd2, v); chk("R1 first byte msb-first", v, 8'hA5);
      rreg(2'd2);
      peek(2'd2, v); chk("R1 second byte", v, 8'h3C);
      rreg(2'd2);
      peek(2'd2, v); chk("R1 empty data port", v, 0);
      peek(2'd1, v); rreg(2'd1); wreg(2'd1, 8'h02);

      // R3: trigger code 1 -> four bytes
      wreg(2'd0, 8'h03);
      peek(2'd1, v); chk("R3 flag low with empty queue", v & 1, 0);
      base = irq_seen;
      for (int k = 0; k < 3; k++) send_bits(8'h10 + 8'(k), 8);
      peek(2'd1, v); chk("R3 flag low below trigger", v & 1, 0);
      send_bits(8'h13, 8);
      peek(2'd1, v); chk("R3 flag high at trigger", v & 1, 1);
      chk("R4 one interrupt pulse", irq_seen - base, 1);

      // R5: clear without prior read is ignored; writing 1 is ignored
      wreg(2'd1, 8'h00);
      peek(2'd1, v); chk("R5 unarmed clear ignored", v & 1, 1);
      rreg(2'd1);
      wreg(2'd1, 8'h01);
      peek(2'd1, v); chk("R5 write of 1 ignored", v & 1, 1);

      // R6: armed clear with count still at trigger re-sets next clock
      @(negedge clk); addr = 2'd1; wd = 8'h00; wr = 1'b1;
      base = irq_seen;
      @(negedge clk); wr = 1'b0; #1;
      chk("R6 flag dips after clear", int'(rdata) & 1, 0);
      @(negedge clk); #1;
      chk("R6 flag sets again", int'(rdata) & 1, 1);
      repeat (2) @(negedge clk);
      chk("R6 second interrupt", irq_seen - base, 1);

      // R7: DMA read pops and clears
      pulse_dma();
      peek(2'd1, v); chk("R7 dma clears flag", v & 1, 0);
      peek(2'd3, v); chk("R7 dma pops one", v, 3);
      peek(2'd2, v); chk("R7 next byte at head", v, 8'h11);
      for (int k = 0; k < 3; k++) rreg(2'd2);

      // R8/R9: overrun at sixteen with trigger code 3
      wreg(2'd0, 8'h07);
      for (int k = 0; k < 16; k++) send_bits(8'h40 + 8'(k), 8);
      peek(2'd3, v); chk("R12 queue full", v, 16);
      peek(2'd1, v); chk("R8 no overrun yet", (v >> 1) & 1, 0);
      send_bits(8'hEE, 8);
      peek(2'd1, v); chk("R8 overrun set", (v >> 1) & 1, 1);
      peek(2'd3, v); chk("R8 byte dropped", v, 16);
      peek(2'd2, v); chk("R8 head intact", v, 8'h40);
      rreg(2'd2);
      send_bits(8'h99, 8);
      peek(2'd3, v); chk("R9 frozen while overrun", v, 15);
      wreg(2'd1, 8'h01);
      peek(2'd1, v); chk("R9 overrun cleared", (v >> 1) & 1, 0);
      send_bits(8'h77, 8);
      peek(2'd3, v); chk("R9 reception resumed", v, 16);
      for (int k = 0; k < 15; k++) rreg(2'd2);
      peek(2'd2, v); chk("R9 resumed byte aligned", v, 8'h77);
      rreg(2'd2);
      peek(2'd3, v); chk("R12 drained", v, 0);

      // R10: disable in the middle of a byte
      wreg(2'd0, 8'h01);
      send_bits(8'hC3 >> 4, 4);
      wreg(2'd0, 8'h00);
      send_bits(8'h03, 4);
      peek(2'd3, v); chk("R10 byte in progress finished", v, 1);
      peek(2'd2, v); chk("R10 finished byte value", v, 8'hC3);
      send_bits(8'h5A, 8);
      peek(2'd3, v); chk("R10 no new byte while disabled", v, 1);

      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule